// File: doc/BRIEF.md
# SMBus Protocol Command Sequencer

This block takes one latched SMBus host command (protocol code, direction, target address, command byte, two data bytes and a small block buffer) and breaks it into the ordered byte-level operations that a downstream bus engine carries out. There are four operations: start-with-address, write a byte, read a byte and stop. The sequencer hands the engine one operation at a time with a one-cycle request pulse. It waits for the engine's done strobe, which carries an acknowledge flag and any byte that was read. Only then does it move on.

When the command ends, the sequencer returns a one-cycle result. The result carries a success or device-error flag, the number of bytes moved on the bus (the address byte included) and the final values of the two data bytes. Block transfers read the outgoing bytes from an external buffer through an address/read-data port. Incoming block bytes are written back to that buffer through a write strobe. Buffer addresses wrap at the buffer depth. Two extra protocol codes are accepted only while an extended-mode input is high. Bit-level clock and data timing belongs to the engine, not to this block.

Top module: `smb_cmd_seq`

## Requirements
- R1: After reset `busy`, `op_go`, `buf_we` and `res_valid` are low. `res_valid` is never high while `busy` is high.
- R2: Every accepted command begins with a start operation (`op_kind` 0) whose byte is {address, direction}, where direction 1 means read. If that operation is not acknowledged, the command ends with `res_err`=1 and `res_cnt`=1, and no further operation is issued.
- R3: Code 0x0 issues start then stop, with count 1.
- R4: Code 0x1 moves one byte: it writes data0 (`op_kind` 1) when the direction is write, or reads one byte into data0 (`op_kind` 2) when it is read. Count is 2.
- R5: Code 0x2 writes the command byte, then writes or reads data0 (count 3). Code 0x3 does the same with data0 followed by data1 (count 4).
- R6: Code 0xC writes data0 then data1 only when the direction is write, then always reads two bytes into data0 and data1. It sends no command byte.
- R7: Code 0x5 writes the command byte, then a length byte. On write the length byte is data0. On read the first byte received becomes data0 and sets how many bytes are read into the buffer; a length of zero reads none. The length byte is counted.
- R8: Code 0xD writes the command byte, then writes data0 bytes taken from buffer entries 0, 1, ... or reads data0 bytes into them. There is no length byte. A length of zero moves no data.
- R9: In a block write, the first data byte that is not acknowledged ends the data phase. That byte is not counted, the stop is still issued and the result is success.
- R10: Code 0xF writes data0 bytes from the buffer, then reads data1 bytes into the buffer from entry 0.
- R11: A code outside the supported set ends one cycle after `start` with `res_err`=1, `res_cnt`=0 and no operation issued. Codes 0x4 and 0x6 count as unsupported while `ext_en` is 0.
- R12: With `ext_en`=1, code 0x4 writes the command byte, data0 and data1 (on write only), then reads two bytes into data0/data1. Code 0x6 writes the command byte, then data0 and data1 (write only), then reads as many buffer bytes as buffer entry 0 held at `start`.
- R13: A new operation is requested only after the previous one reported done, with `op_go` high for exactly one cycle per operation. Buffer indices wrap modulo 2^`BUF_AW`.
- R14: Every command whose address phase was acknowledged ends with a stop operation (`op_kind` 3). `res_valid` rises the cycle after that stop's done, and `res_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a command (ignored while busy) |
| proto | input | 4 | Protocol code |
| rd | input | 1 | Direction, 1 = read |
| ext_en | input | 1 | Enables codes 0x4 and 0x6 |
| dev_addr | input | 7 | Target address |
| cmd_byte | input | 8 | Command byte |
| data0_in | input | 8 | Data byte 0 / length |
| data1_in | input | 8 | Data byte 1 / read length for 0xF |
| op_go | output | 1 | One-cycle operation request |
| op_kind | output | 2 | 0 start, 1 write, 2 read, 3 stop |
| op_byte | output | 8 | Byte for start/write operations |
| op_done | input | 1 | Engine finished the current operation |
| op_ack | input | 1 | Acknowledge seen for that operation |
| op_rdata | input | 8 | Byte read by that operation |
| buf_addr | output | BUF_AW | Block buffer index |
| buf_wdata | output | 8 | Byte to store in the buffer |
| buf_we | output | 1 | Buffer write strobe |
| buf_rdata | input | 8 | Buffer contents at `buf_addr` |
| busy | output | 1 | Command in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_err | output | 1 | Device error |
| res_cnt | output | CNT_W | Bytes moved, address included |
| res_data0 | output | 8 | Final data0 |
| res_data1 | output | 8 | Final data1 |

## Verification
The bound checker watches the operation handshake on every cycle. It confirms that no request goes out while one is outstanding, that each request is a single pulse and that every command opens with a start. It also checks that a refused address or a stop completion produces the right result the next cycle, that illegal or gated codes fail at once with a zero count, and that buffer writes happen only on completed reads. The order and values of the bytes for each protocol, the effect of the length byte, the early end of a refused block write, the buffer contents after block reads and the index wrap can only be shown by the bench's scenarios. There, an engine model with a scripted acknowledge and a varied latency logs each operation.

// File: rtl/smb_seq_pkg.sv
package smb_seq_pkg;
    localparam int NPH = 10;
    localparam int PW  = 4;

    // ordered phases; a command walks the enabled ones upward
    typedef enum logic [PW-1:0] {
        PH_ADDR = 4'd0, PH_CMD = 4'd1, PH_LEN = 4'd2, PH_W0 = 4'd3, PH_W1 = 4'd4,
        PH_BW   = 4'd5, PH_R0  = 4'd6, PH_R1  = 4'd7, PH_BR = 4'd8, PH_STOP = 4'd9
    } phase_e;

    typedef enum logic [1:0] {
        OP_START = 2'd0, OP_WRITE = 2'd1, OP_READ = 2'd2, OP_STOP = 2'd3
    } op_e;

    localparam logic [3:0] P_QUICK = 4'h0;
    localparam logic [3:0] P_BYTE  = 4'h1;
    localparam logic [3:0] P_BDATA = 4'h2;
    localparam logic [3:0] P_WORD  = 4'h3;
    localparam logic [3:0] P_XCALL = 4'h4;
    localparam logic [3:0] P_SBLK  = 4'h5;
    localparam logic [3:0] P_XBLK  = 4'h6;
    localparam logic [3:0] P_CALL  = 4'hC;
    localparam logic [3:0] P_IBLK  = 4'hD;
    localparam logic [3:0] P_UNIV  = 4'hF;
endpackage

// File: rtl/smb_plan_dec.sv
module smb_plan_dec
    import smb_seq_pkg::*;
(
    input  logic [3:0]     proto,
    input  logic           rd,
    input  logic           ext_en,
    input  logic [7:0]     d0,
    input  logic [7:0]     d1,
    input  logic [7:0]     buf0,
    output logic           legal,
    output logic [NPH-1:0] mask,
    output logic [7:0]     wlen,
    output logic [7:0]     rlen
);
    always_comb begin
        mask  = '0;
        legal = 1'b1;
        wlen  = d0;
        rlen  = '0;
        mask[PH_ADDR] = 1'b1;
        mask[PH_STOP] = 1'b1;
        case (proto)
            P_QUICK: ;
            P_BYTE: begin
                mask[PH_R0] = rd;
                mask[PH_W0] = !rd;
            end
            P_BDATA: begin
                mask[PH_CMD] = 1'b1;
                mask[PH_R0]  = rd;
                mask[PH_W0]  = !rd;
            end
            P_WORD: begin
                mask[PH_CMD] = 1'b1;
                mask[PH_R0]  = rd;
                mask[PH_R1]  = rd;
                mask[PH_W0]  = !rd;
                mask[PH_W1]  = !rd;
            end
            P_XCALL, P_CALL: begin
                legal        = (proto == P_CALL) || ext_en;
                mask[PH_CMD] = (proto == P_XCALL) && !rd;
                mask[PH_W0]  = !rd;
                mask[PH_W1]  = !rd;
                mask[PH_R0]  = 1'b1;
                mask[PH_R1]  = 1'b1;
            end
            P_SBLK: begin
                mask[PH_CMD] = 1'b1;
                mask[PH_LEN] = 1'b1;
                mask[PH_BR]  = rd;
                mask[PH_BW]  = !rd && (d0 != 8'd0);
            end
            P_IBLK: begin
                rlen         = d0;
                mask[PH_CMD] = 1'b1;
                mask[PH_BR]  = rd && (d0 != 8'd0);
                mask[PH_BW]  = !rd && (d0 != 8'd0);
            end
            P_XBLK: begin
                legal        = ext_en;
                rlen         = buf0;
                mask[PH_CMD] = 1'b1;
                mask[PH_W0]  = !rd;
                mask[PH_W1]  = !rd;
                mask[PH_BR]  = (buf0 != 8'd0);
            end
            P_UNIV: begin
                rlen        = d1;
                mask[PH_BW] = (d0 != 8'd0);
                mask[PH_BR] = (d1 != 8'd0);
            end
            default: legal = 1'b0;
        endcase
        if (!legal) mask = '0;
    end
endmodule

// File: rtl/smb_phase_pick.sv
module smb_phase_pick #(
    parameter int N  = 10,
    parameter int PW = 4
) (
    input  logic [N-1:0]  mask,
    input  logic [PW-1:0] cur,
    output logic [PW-1:0] nxt,
    output logic          found
);
    // lowest enabled phase strictly above the current one
    always_comb begin
        nxt   = '0;
        found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if ((i > int'(cur)) && mask[i]) begin
                nxt   = PW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/smb_cmd_seq.sv
module smb_cmd_seq
    import smb_seq_pkg::*;
#(
    parameter int BUF_AW = 5,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        proto,
    input  logic              rd,
    input  logic              ext_en,
    input  logic [6:0]        dev_addr,
    input  logic [7:0]        cmd_byte,
    input  logic [7:0]        data0_in,
    input  logic [7:0]        data1_in,
    output logic              op_go,
    output logic [1:0]        op_kind,
    output logic [7:0]        op_byte,
    input  logic              op_done,
    input  logic              op_ack,
    input  logic [7:0]        op_rdata,
    output logic [BUF_AW-1:0] buf_addr,
    output logic [7:0]        buf_wdata,
    output logic              buf_we,
    input  logic [7:0]        buf_rdata,
    output logic              busy,
    output logic              res_valid,
    output logic              res_err,
    output logic [CNT_W-1:0]  res_cnt,
    output logic [7:0]        res_data0,
    output logic [7:0]        res_data1
);
    localparam int LEN_W = 8;

    typedef struct packed {
        logic             active;
        phase_e           ph;
        logic [NPH-1:0]   mask;
        logic             go;
        logic [LEN_W-1:0] idx;
        logic [LEN_W-1:0] rem;
        logic [LEN_W-1:0] wlen;
        logic [LEN_W-1:0] rlen;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       d0;
        logic [7:0]       d1;
        logic             rvalid;
        logic             err;
        logic             rd;
        logic [7:0]       cmd;
        logic [6:0]       addr;
    } seq_t;

    seq_t s_q, s_d;

    logic             dec_legal;
    logic [NPH-1:0]   dec_mask;
    logic [LEN_W-1:0] dec_wlen, dec_rlen;
    logic [NPH-1:0]   mask_nx;
    logic [PW-1:0]    pick_nxt;
    logic             pick_found;

    smb_plan_dec u_dec (
        .proto  (proto),
        .rd     (rd),
        .ext_en (ext_en),
        .d0     (data0_in),
        .d1     (data1_in),
        .buf0   (buf_rdata),
        .legal  (dec_legal),
        .mask   (dec_mask),
        .wlen   (dec_wlen),
        .rlen   (dec_rlen)
    );

    // a zero length byte received on a block read drops the data phase
    always_comb begin
        mask_nx = s_q.mask;
        if (s_q.active && (s_q.ph == PH_LEN) && s_q.rd && op_done && (op_rdata == 8'd0))
            mask_nx[PH_BR] = 1'b0;
    end

    smb_phase_pick #(.N(NPH), .PW(PW)) u_pick (
        .mask  (mask_nx),
        .cur   (s_q.ph),
        .nxt   (pick_nxt),
        .found (pick_found)
    );

    always_comb begin
        logic adv;
        s_d        = s_q;
        s_d.go     = 1'b0;
        s_d.rvalid = 1'b0;
        s_d.mask   = mask_nx;
        adv        = 1'b0;
        if (!s_q.active) begin
            if (start) begin
                s_d.cnt  = '0;
                s_d.err  = 1'b0;
                s_d.idx  = '0;
                s_d.d0   = data0_in;
                s_d.d1   = data1_in;
                s_d.rd   = rd;
                s_d.cmd  = cmd_byte;
                s_d.addr = dev_addr;
                s_d.wlen = dec_wlen;
                s_d.rlen = dec_rlen;
                s_d.mask = dec_mask;
                s_d.ph   = PH_ADDR;
                if (dec_legal) begin
                    s_d.active = 1'b1;
                    s_d.go     = 1'b1;
                end else begin
                    s_d.rvalid = 1'b1;
                    s_d.err    = 1'b1;
                end
            end
        end else if (op_done) begin
            case (s_q.ph)
                PH_ADDR: begin
                    s_d.cnt = CNT_W'(1);
                    if (op_ack) adv = 1'b1;
                    else begin
                        s_d.active = 1'b0;
                        s_d.rvalid = 1'b1;
                        s_d.err    = 1'b1;
                    end
                end
                PH_CMD, PH_W0, PH_W1: begin
                    s_d.cnt = s_q.cnt + 1'b1;
                    adv     = 1'b1;
                end
                PH_LEN: begin
                    s_d.cnt = s_q.cnt + 1'b1;
                    if (s_q.rd) begin
                        s_d.d0   = op_rdata;
                        s_d.rlen = op_rdata;
                    end
                    adv = 1'b1;
                end
                PH_R0: begin
                    s_d.cnt = s_q.cnt + 1'b1;
                    s_d.d0  = op_rdata;
                    adv     = 1'b1;
                end
                PH_R1: begin
                    s_d.cnt = s_q.cnt + 1'b1;
                    s_d.d1  = op_rdata;
                    adv     = 1'b1;
                end
                PH_BW: begin
                    if (op_ack) begin
                        s_d.cnt = s_q.cnt + 1'b1;
                        s_d.idx = s_q.idx + 1'b1;
                        s_d.rem = s_q.rem - 1'b1;
                    end
                    if (!op_ack || (s_q.rem == LEN_W'(1))) adv = 1'b1;
                    else s_d.go = 1'b1;
                end
                PH_BR: begin
                    s_d.cnt = s_q.cnt + 1'b1;
                    s_d.idx = s_q.idx + 1'b1;
                    s_d.rem = s_q.rem - 1'b1;
                    if (s_q.rem == LEN_W'(1)) adv = 1'b1;
                    else s_d.go = 1'b1;
                end
                default: begin
                    s_d.active = 1'b0;
                    s_d.rvalid = 1'b1;
                end
            endcase
            if (adv) begin
                if (pick_found) begin
                    s_d.ph = phase_e'(pick_nxt);
                    s_d.go = 1'b1;
                    if (s_d.ph == PH_BW) begin
                        s_d.rem = s_q.wlen;
                        s_d.idx = '0;
                    end
                    if (s_d.ph == PH_BR) begin
                        s_d.rem = s_d.rlen;
                        s_d.idx = '0;
                    end
                end else begin
                    s_d.active = 1'b0;
                    s_d.rvalid = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (s_q.ph)
            PH_ADDR:             op_kind = OP_START;
            PH_STOP:             op_kind = OP_STOP;
            PH_R0, PH_R1, PH_BR: op_kind = OP_READ;
            PH_LEN:              op_kind = s_q.rd ? OP_READ : OP_WRITE;
            default:             op_kind = OP_WRITE;
        endcase
        case (s_q.ph)
            PH_ADDR:        op_byte = {s_q.addr, s_q.rd};
            PH_CMD:         op_byte = s_q.cmd;
            PH_LEN, PH_W0:  op_byte = s_q.d0;
            PH_W1:          op_byte = s_q.d1;
            PH_BW:          op_byte = buf_rdata;
            default:        op_byte = 8'h00;
        endcase
    end

    assign op_go     = s_q.go;
    assign buf_addr  = s_q.active ? s_q.idx[BUF_AW-1:0] : '0;
    assign buf_wdata = op_rdata;
    assign buf_we    = s_q.active && (s_q.ph == PH_BR) && op_done;
    assign busy      = s_q.active;
    assign res_valid = s_q.rvalid;
    assign res_err   = s_q.err;
    assign res_cnt   = s_q.cnt;
    assign res_data0 = s_q.d0;
    assign res_data1 = s_q.d1;
endmodule

// File: rtl/smb_seq_chk.sv
module smb_seq_chk #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [3:0]       proto,
    input logic             ext_en,
    input logic             op_go,
    input logic [1:0]       op_kind,
    input logic             op_done,
    input logic             op_ack,
    input logic             buf_we,
    input logic             busy,
    input logic             res_valid,
    input logic             res_err,
    input logic [CNT_W-1:0] res_cnt
);
    logic outst_q;

    always_ff @(posedge clk) begin
        if (!rst_n) outst_q <= 1'b0;
        else if (op_go) outst_q <= 1'b1;
        else if (op_done) outst_q <= 1'b0;
    end

    assert_res_not_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !busy);

    assert_first_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (op_go && op_kind == 2'd0));

    assert_addr_nak_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_done && op_kind == 2'd0 && !op_ack) |=>
            (res_valid && res_err && res_cnt == CNT_W'(1) && !busy));

    assert_buf_write_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (op_done && op_kind == 2'd2));

    assert_bad_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && proto == 4'h7) |=>
            (res_valid && res_err && res_cnt == '0 && !op_go));

    assert_ext_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !ext_en && (proto == 4'h4 || proto == 4'h6)) |=>
            (res_valid && res_err && !op_go));

    assert_wait_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
        op_go |-> !outst_q);

    assert_go_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        op_go |=> !op_go);

    assert_stop_ends_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_done && op_kind == 2'd3) |=> (res_valid && !res_err && !busy));
endmodule

bind smb_cmd_seq smb_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .proto     (proto),
    .ext_en    (ext_en),
    .op_go     (op_go),
    .op_kind   (op_kind),
    .op_done   (op_done),
    .op_ack    (op_ack),
    .buf_we    (buf_we),
    .busy      (busy),
    .res_valid (res_valid),
    .res_err   (res_err),
    .res_cnt   (res_cnt)
);

// File: tb/tb_smb_cmd_seq.sv
`timescale 1ns/1ps
module tb_smb_cmd_seq;
    localparam int BUF_AW = 5;
    localparam int CNT_W  = 10;
    localparam int DEPTH  = 1 << BUF_AW;

    typedef struct packed {
        logic [3:0]       req;
        logic [3:0]       proto;
        logic             rd;
        logic             ext;
        logic [7:0]       d0;
        logic [7:0]       d1;
        logic [7:0]       seed;
        logic [7:0]       nak;
        logic [3:0]       lat;
        logic             err;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       nops;
        logic [7:0]       ed0;
        logic [7:0]       ed1;
    } vec_t;

    localparam int NV = 23;
    // buffer is preloaded with entry 0 = 2, entry i = C0+i otherwise
    localparam vec_t VECS [NV] = '{
        '{4'd3,  4'h0, 1'b0, 1'b0, 8'h11, 8'h22, 8'h00, 8'hFF, 4'd0, 1'b0, 10'd1, 8'd2, 8'h11, 8'h22}, // R3 quick
        '{4'd4,  4'h1, 1'b1, 1'b0, 8'h11, 8'h22, 8'h40, 8'hFF, 4'd2, 1'b0, 10'd2, 8'd3, 8'h40, 8'h22}, // R4 byte read
        '{4'd4,  4'h1, 1'b0, 1'b0, 8'h11, 8'h22, 8'h00, 8'hFF, 4'd0, 1'b0, 10'd2, 8'd3, 8'h11, 8'h22}, // R4 byte write
        '{4'd5,  4'h2, 1'b1, 1'b0, 8'h11, 8'h22, 8'h50, 8'hFF, 4'd1, 1'b0, 10'd3, 8'd4, 8'h50, 8'h22}, // R5 byte data read
        '{4'd5,  4'h3, 1'b0, 1'b0, 8'h11, 8'h22, 8'h00, 8'hFF, 4'd0, 1'b0, 10'd4, 8'd5, 8'h11, 8'h22}, // R5 word write
        '{4'd5,  4'h3, 1'b1, 1'b0, 8'h11, 8'h22, 8'h60, 8'hFF, 4'd3, 1'b0, 10'd4, 8'd5, 8'h60, 8'h61}, // R5 word read
        '{4'd6,  4'hC, 1'b0, 1'b0, 8'h11, 8'h22, 8'h70, 8'hFF, 4'd0, 1'b0, 10'd5, 8'd6, 8'h70, 8'h71}, // R6 call write
        '{4'd6,  4'hC, 1'b1, 1'b0, 8'h11, 8'h22, 8'h70, 8'hFF, 4'd1, 1'b0, 10'd3, 8'd4, 8'h70, 8'h71}, // R6 call read
        '{4'd7,  4'h5, 1'b0, 1'b0, 8'h03, 8'h22, 8'h00, 8'hFF, 4'd0, 1'b0, 10'd6, 8'd7, 8'h03, 8'h22}, // R7 block write
        '{4'd7,  4'h5, 1'b1, 1'b0, 8'h11, 8'h22, 8'h02, 8'hFF, 4'd2, 1'b0, 10'd5, 8'd6, 8'h02, 8'h22}, // R7 block read
        '{4'd7,  4'h5, 1'b1, 1'b0, 8'h11, 8'h22, 8'h00, 8'hFF, 4'd0, 1'b0, 10'd3, 8'd4, 8'h00, 8'h22}, // R7 zero length
        '{4'd8,  4'hD, 1'b0, 1'b0, 8'h02, 8'h22, 8'h00, 8'hFF, 4'd0, 1'b0, 10'd4, 8'd5, 8'h02, 8'h22}, // R8 write
        '{4'd8,  4'hD, 1'b1, 1'b0, 8'h03, 8'h22, 8'h80, 8'hFF, 4'd1, 1'b0, 10'd5, 8'd6, 8'h03, 8'h22}, // R8 read
        '{4'd8,  4'hD, 1'b0, 1'b0, 8'h00, 8'h22, 8'h00, 8'hFF, 4'd0, 1'b0, 10'd2, 8'd3, 8'h00, 8'h22}, // R8 zero length
        '{4'd10, 4'hF, 1'b0, 1'b0, 8'h02, 8'h02, 8'h90, 8'hFF, 4'd0, 1'b0, 10'd5, 8'd6, 8'h02, 8'h02}, // R10 universal
        '{4'd2,  4'h3, 1'b0, 1'b0, 8'h11, 8'h22, 8'h00, 8'h00, 4'd0, 1'b1, 10'd1, 8'd1, 8'h11, 8'h22}, // R2 address refused
        '{4'd9,  4'hD, 1'b0, 1'b0, 8'h03, 8'h22, 8'h00, 8'h03, 4'd1, 1'b0, 10'd3, 8'd5, 8'h03, 8'h22}, // R9 refused data
        '{4'd11, 4'h7, 1'b0, 1'b0, 8'h11, 8'h22, 8'h00, 8'hFF, 4'd0, 1'b1, 10'd0, 8'd0, 8'h11, 8'h22}, // R11 bad code
        '{4'd11, 4'h4, 1'b0, 1'b0, 8'h11, 8'h22, 8'h00, 8'hFF, 4'd0, 1'b1, 10'd0, 8'd0, 8'h11, 8'h22}, // R11 gated 4
        '{4'd11, 4'h6, 1'b1, 1'b0, 8'h11, 8'h22, 8'h00, 8'hFF, 4'd0, 1'b1, 10'd0, 8'd0, 8'h11, 8'h22}, // R11 gated 6
        '{4'd12, 4'h4, 1'b0, 1'b1, 8'h11, 8'h22, 8'hA0, 8'hFF, 4'd0, 1'b0, 10'd6, 8'd7, 8'hA0, 8'hA1}, // R12 code 4
        '{4'd12, 4'h6, 1'b0, 1'b1, 8'h11, 8'h22, 8'hB0, 8'hFF, 4'd0, 1'b0, 10'd6, 8'd7, 8'h11, 8'h22}, // R12 code 6 write
        '{4'd12, 4'h6, 1'b1, 1'b1, 8'h11, 8'h22, 8'hB0, 8'hFF, 4'd2, 1'b0, 10'd4, 8'd5, 8'h11, 8'h22}  // R12 code 6 read
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [3:0] proto = '0;
    logic rd = 1'b0, ext_en = 1'b0;
    logic [6:0] dev_addr = 7'h2A;
    logic [7:0] cmd_byte = 8'h5C, data0_in = '0, data1_in = '0;
    logic op_go, op_done = 1'b0, op_ack = 1'b0;
    logic [1:0] op_kind;
    logic [7:0] op_byte, op_rdata = '0;
    logic [BUF_AW-1:0] buf_addr;
    logic [7:0] buf_wdata, buf_rdata;
    logic buf_we, busy, res_valid, res_err;
    logic [CNT_W-1:0] res_cnt;
    logic [7:0] res_data0, res_data1;

    always #2.5 clk = ~clk;

    smb_cmd_seq #(.BUF_AW(BUF_AW), .CNT_W(CNT_W)) dut (.*);

    // block buffer
    logic [7:0] mem [DEPTH];
    assign buf_rdata = mem[buf_addr];
    always @(posedge clk) if (buf_we) mem[buf_addr] <= buf_wdata;

    // engine model
    int otot = 0, rtot = 0, obase = 0, rbase = 0;
    logic [7:0] seed_v = '0, nak_v = 8'hFF;
    logic [3:0] lat_v = '0;
    logic pend = 1'b0;
    int wcnt = 0, cur_idx = 0;
    logic [1:0] cur_kind = '0;
    logic [1:0] log_kind [1024];
    logic [7:0] log_byte [1024];

    always @(negedge clk) begin
        op_done <= 1'b0;
        if (pend) begin
            if (wcnt == 0) begin
                op_done  <= 1'b1;
                op_ack   <= (cur_idx != int'(nak_v));
                op_rdata <= seed_v + 8'(rtot - rbase);
                if (cur_kind == 2'd2) rtot <= rtot + 1;
                pend <= 1'b0;
            end else begin
                wcnt <= wcnt - 1;
            end
        end
        if (op_go) begin
            pend     <= 1'b1;
            wcnt     <= int'(lat_v);
            cur_idx  <= otot - obase;
            cur_kind <= op_kind;
            log_kind[otot % 1024] <= op_kind;
            log_byte[otot % 1024] <= op_byte;
            otot <= otot + 1;
        end
    end

    int nchk = 0, nfail = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_cmd(input vec_t v);
        int guard;
        @(negedge clk);
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'hC0 + 8'(i);
        mem[0] = 8'd2;
        obase = otot; rbase = rtot;
        seed_v = v.seed; nak_v = v.nak; lat_v = v.lat;
        proto = v.proto; rd = v.rd; ext_en = v.ext;
        data0_in = v.d0; data1_in = v.d1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (!res_valid && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic check_res(input vec_t v);
        string r;
        r = $sformatf("R%0d", v.req);
        chk(r, "err", int'(res_err), int'(v.err));
        chk(r, "count", int'(res_cnt), int'(v.cnt));
        chk(r, "ops", otot - obase, int'(v.nops));
        chk(r, "data0", int'(res_data0), int'(v.ed0));
        chk(r, "data1", int'(res_data1), int'(v.ed1));
        if (!v.err) chk("R14", "last op stop", int'(log_kind[(otot - 1) % 1024]), 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "res_valid", int'(res_valid), 0);
        chk("R1", "op_go", int'(op_go), 0);
        chk("R1", "buf_we", int'(buf_we), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            run_cmd(VECS[k]);
            check_res(VECS[k]);
            chk("R2", "first op", (otot > obase) ? int'(log_kind[obase % 1024]) : 0, 0);
        end

        // R5 byte order of a word write: start {2A,0}, cmd, data0, data1
        run_cmd(VECS[4]);
        chk("R5", "addr byte", int'(log_byte[obase % 1024]), 8'h54);
        chk("R5", "cmd byte", int'(log_byte[(obase + 1) % 1024]), 8'h5C);
        chk("R5", "data0 byte", int'(log_byte[(obase + 2) % 1024]), 8'h11);
        chk("R5", "data1 byte", int'(log_byte[(obase + 3) % 1024]), 8'h22);

        // R7 block read with length byte fills the buffer from entry 0
        run_cmd(VECS[9]);
        @(negedge clk);
        chk("R7", "buf0", int'(mem[0]), 8'h03);
        chk("R7", "buf1", int'(mem[1]), 8'h04);
        chk("R7", "buf2 untouched", int'(mem[2]), 8'hC2);

        // R8 block write sends buffer entries in order
        run_cmd(VECS[11]);
        chk("R8", "first data", int'(log_byte[(obase + 2) % 1024]), 8'h02);
        chk("R8", "second data", int'(log_byte[(obase + 3) % 1024]), 8'hC1);

        // R10 universal reads land at buffer entry 0 onward
        run_cmd(VECS[14]);
        @(negedge clk);
        chk("R10", "buf0", int'(mem[0]), 8'h90);
        chk("R10", "buf1", int'(mem[1]), 8'h91);

        // R13 index wraps at buffer depth: 33-byte raw block read
        v = VECS[12];
        v.d0 = 8'(DEPTH + 1); v.seed = 8'h00;
        run_cmd(v);
        @(negedge clk);
        chk("R13", "count", int'(res_cnt), DEPTH + 3);
        chk("R13", "wrapped buf0", int'(mem[0]), DEPTH);
        chk("R13", "buf1", int'(mem[1]), 1);

        // R11 start while idle after errors still works
        run_cmd(VECS[0]);
        check_res(VECS[0]);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule